// File: doc/BRIEF.md
# Daisy-Chained TDM Serial Output Port

This block is the serial output stage of one device in a chain of up to four identical devices that share a single time-division-multiplexed audio frame. A frame is 256 bit clocks long and holds eight 32-bit slots. The device places its own stereo pair in slots 0 and 1, channel A first and then channel B. It fills slots 2 to 7 with the serial stream arriving from the upstream device, delayed by exactly two slots. Each device in the chain therefore moves the upstream pairs two slots later and puts its own pair at the front.

The port either generates the bit clock and frame clock itself (master) or follows external ones (slave). The choice is taken from a select input in the first system clock cycle after reset. All logic runs on one fast system clock. In master mode the bit clock is a divided version of that clock. In slave mode the external clocks are synchronised and their edges are detected. New channel samples arrive on a parallel bus with a valid strobe and take effect at the next frame start. After reset the output stays disabled for a programmable number of bit clocks.

Top module: `tdm_chain_port`

## Requirements
- R1: While `rstN` is low, `serialOut`, `serialOutEn`, `bclkOut` and `fclkOut` are all 0.
- R2: The mode (1 = master) is taken from `masterSel` in the first clock after reset release. Later changes of `masterSel` have no effect until the next reset.
- R3: In master mode `bclkOut` has a period of 2*CLK_DIV system clocks. `fclkOut` changes only on falling bit-clock edges. It is high at the rising edges of frame positions 0 to 127 and low at positions 128 to 255.
- R4: `serialOutEn` goes to 1 at the SETTLE_BCLKS-th rising bit-clock edge after reset and stays 1. `serialOut` is 0 until then and until the first frame start.
- R5: A frame start is a rising bit-clock edge at which the frame clock is high and was low at the previous rising edge. That edge is position 0. The bit for frame position p is driven after the falling edge that follows the rising edge of position p. It is valid at the rising edge of position p+1.
- R6: Slot s covers positions 32*s to 32*s+31. Slot 0 carries channel A and slot 1 carries channel B. Each is sign-extended from SAMPLE_W bits to 32 bits and sent MSB first, so the LSB is in the last position of the slot.
- R7: For positions p from 64 to 255, the output bit is the chain-input value sampled at the rising edge of position p-63. That value is the upstream device's frame bit p-64, a fixed delay of 64 bit clocks.
- R8: A `sampleValid` pulse stores `sampleA`/`sampleB`. If several pulses arrive within one frame, the last one wins. Stored values are applied at the next frame start, so the frame being sent is never altered.
- R9: In slave mode `bclkOut` and `fclkOut` stay 0. Framing and data follow `bclkIn`/`fclkIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterSel | input | 1 | Mode select, 1 = master; taken once after reset |
| sampleA | input | SAMPLE_W | Channel A sample (two's complement) |
| sampleB | input | SAMPLE_W | Channel B sample (two's complement) |
| sampleValid | input | 1 | Strobe that stores sampleA/sampleB |
| bclkIn | input | 1 | External bit clock (slave mode) |
| fclkIn | input | 1 | External frame clock (slave mode) |
| chainIn | input | 1 | Serial stream from the upstream device |
| bclkOut | output | 1 | Generated bit clock (master mode) |
| fclkOut | output | 1 | Generated frame clock (master mode) |
| serialOut | output | 1 | Serial TDM data |
| serialOutEn | output | 1 | Output enable after settling |

## Verification
The assertions assume three things about the inputs. In slave mode the external bit clock stays at one level for several system clocks. The frame clock and chain data change only near falling bit-clock edges, never close to a rising one. `sampleValid` never coincides with a frame-start edge. The bench generates slave clocks with six system clocks per half period. It moves the frame clock and chain data just after each falling edge. It writes samples only at frame positions 10 and 40, far from any frame start.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

  // Control-to-datapath strobes, all single system-clock pulses except active
  typedef struct packed {
    logic bitRise;     // rising bit-clock edge detected this cycle
    logic bitFall;     // falling bit-clock edge detected this cycle
    logic frameStart;  // this rising edge is frame position 0
    logic active;      // settled and locked to a frame: data may be sent
  } tdmStrobe_t;

endpackage

// File: rtl/tdm_chain_ctrl.sv
module tdm_chain_ctrl
  import tdm_chain_pkg::*;
#(
  parameter int SLOT_W       = 32,
  parameter int SLOTS        = 8,
  parameter int CLK_DIV      = 4,
  parameter int SETTLE_BCLKS = 40,
  localparam int FRAME_BITS  = SLOT_W * SLOTS,
  localparam int POS_W       = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterSel,
  input  logic             bclkIn,
  input  logic             fclkIn,
  output logic             bclkOut,
  output logic             fclkOut,
  output tdmStrobe_t       strb,
  output logic [POS_W-1:0] bitPos,
  output logic             settled
);

  localparam int HALF  = FRAME_BITS / 2;
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int SET_W = $clog2(SETTLE_BCLKS + 1);

  logic             modeLatched;
  logic             modeMaster;
  logic [DIV_W-1:0] divCnt;
  logic             bclkReg;
  logic             fclkReg;
  logic [1:0]       bSync;
  logic [1:0]       fSync;
  logic             bPrev;
  logic             fclkPrev;
  logic             locked;
  logic [SET_W-1:0] settleCnt;

  logic             divWrap;
  logic             masterRise, masterFall;
  logic             slaveRise, slaveFall;
  logic             bitRise, bitFall;
  logic             fclkAtRise;
  logic             frameStart;
  logic [POS_W-1:0] nextPos;

  // Mode capture: once, in the first cycle after reset release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeLatched <= 1'b0;
      modeMaster  <= 1'b0;
    end else if (!modeLatched) begin
      modeLatched <= 1'b1;
      modeMaster  <= masterSel;
    end
  end

  // Master bit-clock divider
  assign divWrap    = modeLatched && modeMaster && (divCnt == DIV_W'(CLK_DIV - 1));
  assign masterRise = divWrap && !bclkReg;
  assign masterFall = divWrap && bclkReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      bclkReg <= 1'b0;
    end else if (modeLatched && modeMaster) begin
      divCnt <= divWrap ? '0 : divCnt + 1'b1;
      if (divWrap) bclkReg <= !bclkReg;
    end
  end

  // Slave clock synchronisers and edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      fSync <= '0;
      bPrev <= 1'b0;
    end else begin
      bSync <= {bSync[0], bclkIn};
      fSync <= {fSync[0], fclkIn};
      bPrev <= bSync[1];
    end
  end

  assign slaveRise = modeLatched && !modeMaster && bSync[1] && !bPrev;
  assign slaveFall = modeLatched && !modeMaster && !bSync[1] && bPrev;

  assign bitRise    = masterRise || slaveRise;
  assign bitFall    = masterFall || slaveFall;
  assign fclkAtRise = modeMaster ? fclkReg : fSync[1];
  assign frameStart = bitRise && fclkAtRise && !fclkPrev;
  assign nextPos    = (bitPos == POS_W'(FRAME_BITS - 1)) ? '0 : bitPos + 1'b1;

  // Frame position, lock and frame-clock generation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitPos   <= POS_W'(FRAME_BITS - 2);
      fclkPrev <= 1'b1;
      locked   <= 1'b0;
      fclkReg  <= 1'b0;
    end else begin
      if (bitRise) begin
        fclkPrev <= fclkAtRise;
        bitPos   <= frameStart ? '0 : nextPos;
        if (frameStart) locked <= 1'b1;
      end
      if (masterFall) fclkReg <= (nextPos < POS_W'(HALF));
    end
  end

  // Post-reset settling, counted in rising bit-clock edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
      settled   <= 1'b0;
    end else if (bitRise && !settled) begin
      settleCnt <= settleCnt + 1'b1;
      if (settleCnt == SET_W'(SETTLE_BCLKS - 1)) settled <= 1'b1;
    end
  end

  assign bclkOut         = bclkReg;
  assign fclkOut         = fclkReg;
  assign strb.bitRise    = bitRise;
  assign strb.bitFall    = bitFall;
  assign strb.frameStart = frameStart;
  assign strb.active     = settled && locked;

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rstN)
    modeLatched |=> $stable(modeMaster))
    else $error("mode changed after capture");

  assert_fclk_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fclkOut != $past(fclkOut)) |-> $past(masterFall))
    else $error("frame clock moved outside a falling bit-clock edge");

  assert_settled_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    settled |=> settled)
    else $error("settled flag dropped");

  assert_pos_zero_at_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (bitPos == '0))
    else $error("position not zero after frame start");

  assert_slave_clocks_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeLatched && !modeMaster) |-> (!bclkOut && !fclkOut))
    else $error("clock outputs active in slave mode");

endmodule

// File: rtl/tdm_chain_datapath.sv
module tdm_chain_datapath
  import tdm_chain_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int SLOTS       = 8,
  localparam int FRAME_BITS = SLOT_W * SLOTS,
  localparam int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  tdmStrobe_t          strb,
  input  logic [POS_W-1:0]    bitPos,
  input  logic [SAMPLE_W-1:0] sampleA,
  input  logic [SAMPLE_W-1:0] sampleB,
  input  logic                sampleValid,
  input  logic                chainIn,
  output logic                serialOut
);

  localparam int SLOT_BITS = $clog2(SLOT_W);
  localparam int SI_W      = POS_W - SLOT_BITS;
  localparam int DLY       = 2 * SLOT_W;

  logic [SLOT_W-1:0]    extA, extB;
  logic [SLOT_W-1:0]    pendA, pendB;
  logic [SLOT_W-1:0]    frameA, frameB;
  logic [1:0]           chainSync;
  logic [DLY-1:0]       dly;
  logic [SI_W-1:0]      slotIdx;
  logic [SLOT_BITS-1:0] bitIdx;
  logic [SLOT_BITS-1:0] wordIdx;
  logic                 ownBit;
  logic                 outBit;

  // Sign extension of the samples to slot width
  generate
    if (SAMPLE_W == SLOT_W) begin : g_full
      assign extA = sampleA;
      assign extB = sampleB;
    end else begin : g_ext
      assign extA = {{(SLOT_W - SAMPLE_W){sampleA[SAMPLE_W-1]}}, sampleA};
      assign extB = {{(SLOT_W - SAMPLE_W){sampleB[SAMPLE_W-1]}}, sampleB};
    end
  endgenerate

  // Pending words (last write wins) and frame words (taken at frame start)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendA  <= '0;
      pendB  <= '0;
      frameA <= '0;
      frameB <= '0;
    end else begin
      if (sampleValid) begin
        pendA <= extA;
        pendB <= extB;
      end
      if (strb.frameStart) begin
        frameA <= pendA;
        frameB <= pendB;
      end
    end
  end

  // Chain input: synchronise, then a two-slot delay line clocked by rising edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainSync <= '0;
      dly       <= '0;
    end else begin
      chainSync <= {chainSync[0], chainIn};
      if (strb.bitRise) dly <= {dly[DLY-2:0], chainSync[1]};
    end
  end

  // Bit selection for the current position
  assign slotIdx = bitPos[POS_W-1:SLOT_BITS];
  assign bitIdx  = bitPos[SLOT_BITS-1:0];
  assign wordIdx = SLOT_BITS'(SLOT_W - 1) - bitIdx;
  assign ownBit  = (slotIdx == '0) ? frameA[wordIdx] : frameB[wordIdx];
  assign outBit  = (slotIdx < SI_W'(2)) ? ownBit : dly[DLY-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serialOut <= 1'b0;
    end else if (strb.bitFall) begin
      serialOut <= strb.active ? outBit : 1'b0;
    end
  end

  assert_quiet_until_active_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.active && strb.bitFall) |=> !serialOut)
    else $error("data driven before the port is active");

  assert_out_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (serialOut != $past(serialOut)) |-> $past(strb.bitFall))
    else $error("serial output changed outside a falling edge");

  assert_frame_word_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((frameA != $past(frameA)) || (frameB != $past(frameB))) |-> $past(strb.frameStart))
    else $error("frame word changed mid-frame");

endmodule

// File: rtl/tdm_chain_port.sv
module tdm_chain_port
  import tdm_chain_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int SLOT_W       = 32,
  parameter int SLOTS        = 8,
  parameter int CLK_DIV      = 4,
  parameter int SETTLE_BCLKS = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterSel,
  input  logic [SAMPLE_W-1:0] sampleA,
  input  logic [SAMPLE_W-1:0] sampleB,
  input  logic                sampleValid,
  input  logic                bclkIn,
  input  logic                fclkIn,
  input  logic                chainIn,
  output logic                bclkOut,
  output logic                fclkOut,
  output logic                serialOut,
  output logic                serialOutEn
);

  localparam int POS_W = $clog2(SLOT_W * SLOTS);

  tdmStrobe_t       strb;
  logic [POS_W-1:0] bitPos;

  tdm_chain_ctrl #(
    .SLOT_W(SLOT_W), .SLOTS(SLOTS), .CLK_DIV(CLK_DIV), .SETTLE_BCLKS(SETTLE_BCLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .masterSel(masterSel),
    .bclkIn(bclkIn), .fclkIn(fclkIn),
    .bclkOut(bclkOut), .fclkOut(fclkOut),
    .strb(strb), .bitPos(bitPos), .settled(serialOutEn)
  );

  tdm_chain_datapath #(
    .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .bitPos(bitPos),
    .sampleA(sampleA), .sampleB(sampleB), .sampleValid(sampleValid),
    .chainIn(chainIn), .serialOut(serialOut)
  );

endmodule

// File: tb/tdm_chain_port_bench.sv
`timescale 1ns/1ps
module tdm_chain_port_bench;

  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 32;
  localparam int SLOTS    = 8;
  localparam int CLK_DIV  = 4;
  localparam int SETTLE   = 40;
  localparam int FB       = SLOT_W * SLOTS;
  localparam int H        = 6;
  localparam int NFRAMES  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterSel = 1'b0;
  logic [SAMPLE_W-1:0] sampleA = '0, sampleB = '0;
  logic sampleValid = 1'b0;
  logic bclkIn = 1'b0, fclkIn = 1'b0, chainIn = 1'b0;
  logic bclkOut, fclkOut, serialOut, serialOutEn;

  tdm_chain_port #(
    .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS), .CLK_DIV(CLK_DIV), .SETTLE_BCLKS(SETTLE)
  ) u_tdm_chain_port (
    .clk(clk), .rstN(rstN), .masterSel(masterSel), .sampleA(sampleA), .sampleB(sampleB),
    .sampleValid(sampleValid), .bclkIn(bclkIn), .fclkIn(fclkIn), .chainIn(chainIn),
    .bclkOut(bclkOut), .fclkOut(fclkOut), .serialOut(serialOut), .serialOutEn(serialOutEn)
  );

  always #2.5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  longint tickCount = 0;
  longint lastRiseTick = 0;
  bit    benchMaster = 1'b0;
  int    slaveClkViol = 0;
  bit    finished = 1'b0;

  task automatic tick();
    @(negedge clk);
    tickCount++;
    if (!benchMaster && rstN && (bclkOut || fclkOut)) slaveClkViol++;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [SLOT_W-1:0] extend(input logic [SAMPLE_W-1:0] s);
    return {{(SLOT_W - SAMPLE_W){s[SAMPLE_W-1]}}, s};
  endfunction

  function automatic logic [SLOT_W-1:0] expSlot(input int slot, input logic [SAMPLE_W-1:0] a,
                                                input logic [SAMPLE_W-1:0] b, input logic [FB-1:0] u);
    logic [SLOT_W-1:0] w;
    if (slot == 0) return extend(a);
    if (slot == 1) return extend(b);
    for (int j = 0; j < SLOT_W; j++) w[SLOT_W-1-j] = u[slot*SLOT_W + j - 2*SLOT_W];
    return w;
  endfunction

  task automatic riseStep(output logic sOut, output logic fSeen, output logic enSeen,
                          output longint period);
    if (benchMaster) begin
      while (bclkOut) tick();
      while (!bclkOut) tick();
      sOut = serialOut; fSeen = fclkOut; enSeen = serialOutEn;
      period = tickCount - lastRiseTick;
      lastRiseTick = tickCount;
    end else begin
      sOut = serialOut; fSeen = fclkIn; enSeen = serialOutEn; period = 0;
      bclkIn = 1'b1;
      repeat (H) tick();
    end
  endtask

  task automatic fallStep(input logic fNext, input logic chainNext, input bit doWrite,
                          input logic [SAMPLE_W-1:0] wa, input logic [SAMPLE_W-1:0] wb);
    if (benchMaster) begin
      while (bclkOut) tick();
      chainIn = chainNext;
    end else begin
      bclkIn = 1'b0; fclkIn = fNext; chainIn = chainNext;
    end
    if (doWrite) begin
      sampleA = wa; sampleB = wb; sampleValid = 1'b1;
      tick();
      sampleValid = 1'b0;
    end
    if (!benchMaster) repeat (H) tick();
  endtask

  task automatic runMode(input bit master);
    logic s, f, e, prevF;
    longint period;
    int pos, genPos, riseCount, framesDone, framesChecked;
    int zeroViol, fclkViol, periodViol;
    bit haveFrame, frameEn, doWrite;
    logic [FB-1:0] curU, gotBits;
    logic [SAMPLE_W-1:0] curA, curB, pendA, pendB, wa, wb;
    logic [SLOT_W-1:0] gw, ew;

    benchMaster = master;
    rstN = 1'b0; masterSel = master;
    bclkIn = 0; fclkIn = 0; chainIn = 0; sampleValid = 0; sampleA = '0; sampleB = '0;
    repeat (6) tick();
    // R1: reset state
    check(serialOut == 1'b0, "R1", "serialOut in reset", serialOut, 0);
    check(serialOutEn == 1'b0, "R1", "serialOutEn in reset", serialOutEn, 0);
    check(bclkOut == 1'b0, "R1", "bclkOut in reset", bclkOut, 0);
    check(fclkOut == 1'b0, "R1", "fclkOut in reset", fclkOut, 0);
    rstN = 1'b1;
    tick(); tick();
    masterSel = !master;  // R2: must be ignored
    lastRiseTick = tickCount;

    pos = -1; genPos = 250; prevF = 1'b0; riseCount = 0;
    framesDone = 0; framesChecked = 0; zeroViol = 0; fclkViol = 0; periodViol = 0;
    haveFrame = 0; frameEn = 0;
    curA = '0; curB = '0; pendA = '0; pendB = '0; gotBits = '0;
    for (int k = 0; k < FB; k++) curU[k] = 1'($urandom);

    for (int step = 0; step < FB * NFRAMES + 16; step++) begin
      riseStep(s, f, e, period);
      riseCount++;
      if (!e && s) zeroViol++;
      if (master) begin
        if (riseCount > 2 && period != 2 * CLK_DIV) periodViol++;
        if (riseCount == SETTLE - 1) check(!e, "R4", "enable before settle count", e, 0);
        if (riseCount == SETTLE) check(e, "R4", "enable at settle count", e, 1);
      end
      if (f && !prevF) pos = 0;
      else if (pos >= 0) pos = (pos + 1) % FB;
      prevF = f;
      if (master && pos >= 0 && (f != (pos < FB / 2))) fclkViol++;

      if (pos == 0) begin
        if (haveFrame) begin
          gotBits[FB-1] = s;
          frameEn = frameEn && e;
          if (frameEn) begin
            framesChecked++;
            for (int sl = 0; sl < SLOTS; sl++) begin
              for (int j = 0; j < SLOT_W; j++) gw[SLOT_W-1-j] = gotBits[sl*SLOT_W + j];
              ew = expSlot(sl, curA, curB, curU);
              // R5 framing; R6/R8 own slots; R7 forwarded slots
              check(gw == ew, (sl < 2) ? "R5 R6 R8" : "R5 R7",
                    $sformatf("slot %0d", sl), gw, ew);
            end
          end
        end
        haveFrame = 1; frameEn = 1;
        curA = pendA; curB = pendB;
        framesDone++;
        for (int k = 0; k < FB; k++)
          curU[k] = (framesDone == 6) ? 1'b1 : (framesDone == 7) ? 1'b0 : 1'($urandom);
      end else if (pos > 0) begin
        gotBits[pos-1] = s;
        frameEn = frameEn && e;
      end

      doWrite = 0; wa = '0; wb = '0;
      if (pos == 10 && framesDone == 3) begin
        doWrite = 1; wa = {1'b0, {(SAMPLE_W-1){1'b1}}}; wb = {1'b1, {(SAMPLE_W-1){1'b0}}};
      end else if (pos == 10 && framesDone != 5 && ($urandom % 4) != 0) begin
        doWrite = 1; wa = SAMPLE_W'($urandom); wb = SAMPLE_W'($urandom);
      end else if (pos == 40 && framesDone != 3 && framesDone != 5 && ($urandom % 3) == 0) begin
        doWrite = 1; wa = SAMPLE_W'($urandom); wb = SAMPLE_W'($urandom);
      end
      if (doWrite) begin pendA = wa; pendB = wb; end
      fallStep(((genPos + 1) % FB) < FB / 2, (pos >= 0) ? curU[pos] : 1'($urandom),
               doWrite, wa, wb);
      genPos = (genPos + 1) % FB;
    end

    check(zeroViol == 0, "R4", "output zero while disabled", zeroViol, 0);
    check(framesChecked >= NFRAMES - 3, "R2 R9", "frames delivered after select change",
          framesChecked, NFRAMES - 3);
    if (master) begin
      check(periodViol == 0, "R3", "bit clock period errors", periodViol, 0);
      check(fclkViol == 0, "R3", "frame clock level errors", fclkViol, 0);
    end else begin
      check(slaveClkViol == 0, "R2 R9", "clock outputs active in slave", slaveClkViol, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    runMode(1'b1);
    runMode(1'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule